// File: doc/BRIEF.md
# Supply Fault Output Guard

This block sits between the supply monitoring comparators and the output-stage drivers. It takes two debounced fault inputs, one for supply undervoltage and one for supply overvoltage. It produces a single output-stage enable. Either fault drops the enable combinationally, in the same cycle the fault input rises. Each fault also sets a sticky status flag. Software reads the flags through a 16-bit status word, and that read clears them.

A recovery-mode input selects how the outputs come back on. In automatic mode, the enable returns as soon as both fault inputs are low, whatever the flags hold. In latched mode, the enable stays low while either flag is set. Software must read the status word to clear the flags, and it can do so only after the fault has gone. A master enable from the surrounding control logic gates the final enable.

Top module: `supply_fault_guard`

## Requirements
- R1: A read (`rd_en`=1) at address 0x12 returns the undervoltage flag on bit 3 and the overvoltage flag on bit 2, with all other bits 0. A read at any other address, or no read at all, returns 0. The data appears combinationally in the same cycle as the request.
- R2: `stage_en` is 0 in every cycle in which `uv_fault` or `ov_fault` is 1, with no register delay.
- R3: A fault input that is 1 at a rising clock edge sets its flag from that edge onward.
- R4: A read at address 0x12 returns the flag values held before the read. At the following edge it clears every flag whose fault input is 0.
- R5: A read at address 0x12 does not clear a flag whose fault input is still 1 at that edge. The flag stays set.
- R6: With `latch_recover`=0, `stage_en` equals `master_en` whenever both fault inputs are 0, even while flags remain set.
- R7: With `latch_recover`=1, `stage_en` is 0 while either flag is set. It returns to `master_en` only when both fault inputs are 0 and both flags are clear.
- R8: `master_en`=0 forces `stage_en` to 0.
- R9: After reset, both flags are 0 and a status read returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv_fault | input | 1 | Debounced supply undervoltage indication |
| ov_fault | input | 1 | Debounced supply overvoltage indication |
| latch_recover | input | 1 | 1 = latched recovery, 0 = automatic recovery |
| master_en | input | 1 | Enable from the rest of the control logic |
| rd_en | input | 1 | Register read strobe (read-to-clear) |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Read data, 0 when not addressing the status word |
| stage_en | output | 1 | Output-stage enable |

## Verification
`stage_en` and `rd_data` are combinational, so the bench compares them in the cycle the stimulus is applied. A flag change (set, clear or blocked clear) becomes visible only after the next rising edge. Each driver step therefore pushes the outputs expected for its own cycle, then moves the bench's flag model past the edge. The monitor samples 1 ns after the driver has settled the inputs, well before that edge. Latched-mode recovery is checked across the cycle of the clearing read and the cycle after it, so the one-cycle delay on re-enable is pinned down exactly.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned SFP_ADDR_W = 8;
  localparam int unsigned SFP_DATA_W = 16;
  localparam int unsigned SFP_NFAULT = 2;
  localparam int unsigned SFP_UV_IDX = 0;
  localparam int unsigned SFP_OV_IDX = 1;

  typedef enum logic {
    RECOVER_AUTO  = 1'b0,
    RECOVER_LATCH = 1'b1
  } recover_mode_e;

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic gate_enable(input logic master, input logic any_fault,
                                       input logic any_flag, input recover_mode_e mode);
    return master & ~any_fault & ~((mode == RECOVER_LATCH) & any_flag);
  endfunction
endpackage

// File: rtl/sfp_flag.sv
module sfp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic clr_req,
  output logic flag_q,
  output logic clr_blocked
);
  import sfp_pkg::*;

  assign clr_blocked = clr_req & fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, fault, clr_req);
  end
endmodule

// File: rtl/sfp_readport.sv
module sfp_readport #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NFAULT      = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h12,
  parameter int unsigned UV_POS      = 3,
  parameter int unsigned OV_POS      = 2
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NFAULT-1:0] flags,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned POS_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] pack_word(input logic [NFAULT-1:0] f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POS_W'(UV_POS)] = f[sfp_pkg::SFP_UV_IDX];
    w[POS_W'(OV_POS)] = f[sfp_pkg::SFP_OV_IDX];
    return w;
  endfunction

  assign rd_hit  = rd_en && (rd_addr == STATUS_ADDR);
  assign rd_data = rd_hit ? pack_word(flags) : '0;
endmodule

// File: rtl/sfp_gate.sv
module sfp_gate #(
  parameter int unsigned NFAULT = 2
) (
  input  logic              master_en,
  input  logic              latch_recover,
  input  logic [NFAULT-1:0] faults,
  input  logic [NFAULT-1:0] flags,
  output logic              any_fault,
  output logic              any_flag,
  output logic              stage_en
);
  import sfp_pkg::*;

  recover_mode_e mode;

  assign mode      = recover_mode_e'(latch_recover);
  assign any_fault = |faults;
  assign any_flag  = |flags;
  assign stage_en  = gate_enable(master_en, any_fault, any_flag, mode);
endmodule

// File: rtl/supply_fault_guard.sv
module supply_fault_guard #(
  parameter int unsigned ADDR_W      = sfp_pkg::SFP_ADDR_W,
  parameter int unsigned DATA_W      = sfp_pkg::SFP_DATA_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h12,
  parameter int unsigned UV_POS      = 3,
  parameter int unsigned OV_POS      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_fault,
  input  logic              ov_fault,
  input  logic              latch_recover,
  input  logic              master_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              stage_en
);
  import sfp_pkg::*;
  localparam int unsigned NF = SFP_NFAULT;

  logic [NF-1:0] fault_vec;
  logic [NF-1:0] flag_vec;
  logic [NF-1:0] clr_blocked;
  logic          rd_hit;
  logic          any_fault;
  logic          any_flag;

  assign fault_vec[SFP_UV_IDX] = uv_fault;
  assign fault_vec[SFP_OV_IDX] = ov_fault;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    sfp_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault      (fault_vec[i]),
      .clr_req    (rd_hit),
      .flag_q     (flag_vec[i]),
      .clr_blocked(clr_blocked[i])
    );
  end

  sfp_readport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFAULT(NF),
    .STATUS_ADDR(STATUS_ADDR), .UV_POS(UV_POS), .OV_POS(OV_POS)
  ) u_read (
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .flags  (flag_vec),
    .rd_hit (rd_hit),
    .rd_data(rd_data)
  );

  sfp_gate #(.NFAULT(NF)) u_gate (
    .master_en    (master_en),
    .latch_recover(latch_recover),
    .faults       (fault_vec),
    .flags        (flag_vec),
    .any_fault    (any_fault),
    .any_flag     (any_flag),
    .stage_en     (stage_en)
  );
endmodule

// File: rtl/supply_fault_guard_chk.sv
module supply_fault_guard_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned UV_POS = 3,
  parameter int unsigned OV_POS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uv_fault,
  input logic              ov_fault,
  input logic              latch_recover,
  input logic              master_en,
  input logic              rd_hit,
  input logic [1:0]        flag_vec,
  input logic [DATA_W-1:0] rd_data,
  input logic              stage_en
);
  localparam logic [DATA_W-1:0] MASK = (DATA_W'(1) << UV_POS) | (DATA_W'(1) << OV_POS);

  a_r1_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~MASK) == '0);
  a_r2_fault_blocks_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_fault || ov_fault) |-> !stage_en);
  a_r3_uv_sets: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> flag_vec[0]);
  a_r3_ov_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ov_fault |=> flag_vec[1]);
  a_r4_read_clears_uv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !uv_fault) |=> !flag_vec[0]);
  a_r5_blocked_clear_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ov_fault) |=> flag_vec[1]);
  a_r6_auto_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_recover && !uv_fault && !ov_fault && master_en) |-> stage_en);
  a_r7_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_recover && (flag_vec != 2'b00)) |-> !stage_en);
  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !stage_en);
endmodule

bind supply_fault_guard supply_fault_guard_chk #(
  .DATA_W(DATA_W), .UV_POS(UV_POS), .OV_POS(OV_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .uv_fault(uv_fault), .ov_fault(ov_fault),
  .latch_recover(latch_recover), .master_en(master_en), .rd_hit(rd_hit),
  .flag_vec(flag_vec), .rd_data(rd_data), .stage_en(stage_en)
);

// File: tb/tb_supply_fault_guard.sv
`timescale 1ns/1ps
module tb_supply_fault_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uv_fault = 1'b0, ov_fault = 1'b0, latch_recover = 1'b0;
  logic        master_en = 1'b1, rd_en = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [15:0] rd_data;
  logic        stage_en;

  always #5 clk = ~clk;

  supply_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .uv_fault(uv_fault), .ov_fault(ov_fault),
    .latch_recover(latch_recover), .master_en(master_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .stage_en(stage_en)
  );

  typedef struct {
    logic        en;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic m_uv = 1'b0, m_ov = 1'b0;

  // Driver: applies one cycle of stimulus and pushes what the requirements predict.
  task automatic step(input logic uv, input logic ov, input logic lm, input logic me,
                      input logic rd, input logic [7:0] addr, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    uv_fault = uv; ov_fault = ov; latch_recover = lm; master_en = me;
    rd_en = rd; rd_addr = addr;
    hit    = rd && (addr == 8'h12);
    e.data = hit ? ((16'(m_uv) << 3) | (16'(m_ov) << 2)) : 16'h0000;
    e.en   = me && !uv && !ov && !(lm && (m_uv || m_ov));
    e.tag  = tag;
    q.push_back(e);
    -> sample_ev;
    if (uv) m_uv = 1'b1; else if (hit) m_uv = 1'b0;
    if (ov) m_ov = 1'b1; else if (hit) m_ov = 1'b0;
  endtask

  // Monitor: compares the outputs shortly after the inputs settle.
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (stage_en !== e.en || rd_data !== e.data) begin
          fails++;
          $display("FAIL %s: stage_en=%0b rd_data=%04h expected stage_en=%0b rd_data=%04h",
                   e.tag, stage_en, rd_data, e.en, e.data);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // uv ov lm me rd addr
    step(0,0,0,1,1,8'h12,"R9 status zero after reset");
    step(0,0,0,0,0,8'h00,"R8 master low disables");
    step(1,0,0,1,0,8'h00,"R2 uv drops enable same cycle");
    step(0,0,0,1,1,8'h12,"R3 R6 uv flag reads bit3, auto enable");
    step(0,0,0,1,1,8'h12,"R4 flag cleared by read");
    step(0,1,0,1,0,8'h00,"R2 ov drops enable");
    step(0,1,0,1,1,8'h12,"R5 read during ov returns bit2");
    step(0,0,0,1,1,8'h12,"R5 ov flag survived read");
    step(0,0,0,1,1,8'h12,"R4 ov flag now clear");
    step(1,0,0,1,0,8'h00,"R2 uv pulse");
    step(0,0,0,1,1,8'h11,"R1 wrong address reads zero");
    step(0,0,0,1,0,8'h12,"R1 no strobe reads zero");
    step(0,0,0,1,1,8'h12,"R1 uv flag at bit3");
    step(0,0,1,1,0,8'h00,"R7 latched clean start enabled");
    step(1,0,1,1,0,8'h00,"R2 latched uv");
    step(0,0,1,1,0,8'h00,"R7 latched hold after recovery");
    step(0,0,1,1,0,8'h00,"R7 still held");
    step(0,0,1,1,1,8'h12,"R7 clearing read still disabled");
    step(0,0,1,1,0,8'h00,"R7 re-enabled after clear");
    step(1,1,1,1,0,8'h00,"R2 both faults");
    step(0,0,1,1,1,8'h12,"R1 both flags read 000c");
    step(0,0,1,1,0,8'h00,"R7 re-enabled after both cleared");
    step(1,0,1,1,0,8'h00,"R3 latched uv set");
    step(1,0,1,1,1,8'h12,"R5 read while uv present");
    step(0,0,1,1,0,8'h00,"R5 uv flag kept, latched off");
    step(0,0,1,1,1,8'h12,"R4 latched clear");
    step(0,0,1,0,0,8'h00,"R8 master low in latched mode");
    step(0,0,1,1,0,8'h00,"R7 enabled");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule